// File: doc/BRIEF.md
# PLL Automatic Holdover Controller

This block decides when a PLL's charge pump must stop driving the loop filter because the loop has lost its reference. It watches the digital lock-detect flag (`dld`), the lock-detect pin level (`ld_level`) and a one-cycle strobe for each candidate reference that marks a reference edge at the phase-frequency detector. When lock drops while the PLL is enabled and the lock-detect level was high at that moment, the controller puts the charge pump into high impedance. The VCO then coasts near its last frequency while the dividers keep counting.

The controller leaves holdover on the first edge of the currently selected reference. On that edge it releases the charge pump and, in the same cycle, sends a one-cycle synchronous reset to the feedback B counter so that the two divider outputs start close in phase. It then refuses to re-enter holdover until the loop has locked again. A fresh lock means `dld` held high for `CLEAN_CYC` consecutive clock cycles. A low cycle during that count restarts it. All inputs are taken as already synchronous to `clk`.

The state machine has three states. ST_ARMED is the reset state: the charge pump is driven and the controller waits for a qualified loss of lock. ST_HOLD holds the charge pump in high impedance. ST_RELOCK has the charge pump driven and re-entry blocked. The transitions are:
- arm_to_hold: a qualified `dld` fall while enabled.
- hold_to_relock: a selected reference edge.
- relock_to_arm: a clean relock.
- any_to_arm: `pll_en` low or reset.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cp_hiz`, `bcnt_rst` and `hold_busy` are all 0 and the state is ST_ARMED.
- R2: In ST_ARMED with `pll_en`=1, a cycle in which `dld` is 0 after being 1 in the previous cycle, with the effective LD level high, sets `cp_hiz`=1 and `hold_busy`=1 from the next clock edge.
- R3: With `ld_cmp_en`=1, the LD level used is `ld_level` sampled in the cycle of the `dld` fall. If it is 0 there, no holdover starts, and a later rise of `ld_level` while `dld` stays low does not start one.
- R4: With `ld_cmp_en`=0, the effective LD level is always high, so a `dld` fall enters holdover whatever `ld_level` is.
- R5: In ST_HOLD, only bit `ref_edge[ref_sel]` can end holdover. Strobes on other bits are ignored, and a `ref_sel` value of `NUM_REFS` or more selects no reference.
- R6: A selected reference strobe in ST_HOLD clears `cp_hiz` and raises `bcnt_rst` at the same clock edge. `bcnt_rst` lasts exactly one cycle.
- R7: In ST_RELOCK, falls of `dld` never restart holdover. The controller returns to ST_ARMED only after `dld` has been 1 for `CLEAN_CYC` consecutive cycles, and any 0 cycle restarts that count.
- R8: `pll_en`=0 forces ST_ARMED with `cp_hiz`=0 and no `bcnt_rst` at the next edge, and no holdover starts while it is 0.
- R9: A reference strobe in the same cycle as the qualifying `dld` fall does not release the charge pump. Release needs a strobe in a later cycle.
- R10: `hold_busy` is 1 exactly when the state is ST_HOLD or ST_RELOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_en | input | 1 | PLL enabled |
| dld | input | 1 | Digital lock-detect flag |
| ld_level | input | 1 | Lock-detect pin level |
| ld_cmp_en | input | 1 | 1: use `ld_level`; 0: treat the LD level as high |
| ref_edge | input | NUM_REFS | One-cycle reference-edge strobe per reference |
| ref_sel | input | SEL_W | Index of the active reference |
| cp_hiz | output | 1 | Charge pump held in high impedance |
| bcnt_rst | output | 1 | One-cycle synchronous reset for the feedback B counter |
| hold_busy | output | 1 | Controller in ST_HOLD or ST_RELOCK |

## Verification
The release of the charge pump and the B-counter reset must happen in the same cycle. The bench checks `cp_hiz` falling together with a single `bcnt_rst` pulse after every selected reference strobe. It also makes a reference strobe arrive in the very cycle that `dld` falls. It expects holdover to be entered and not released, with the release and reset pulse appearing only at the next selected strobe. The drop of `pll_en` out of ST_HOLD is judged against the same pair: `cp_hiz` clears and no reset pulse appears.

// File: rtl/holdover_pkg.sv
package holdover_pkg;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RELOCK = 2'd2
    } hold_state_t;

endpackage

// File: rtl/hold_lock_edge.sv
// Detects the falling edge of the lock flag and qualifies it with the
// lock-detect level seen in that same cycle.
module hold_lock_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic dld,
    input  logic ld_level,
    input  logic ld_cmp_en,
    output logic fall_qual
);

    logic dld_q;
    logic ld_eff;

    // Cleared at reset: no fall can be seen until lock has been high once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dld_q <= 1'b0;
        end else begin
            dld_q <= dld;
        end
    end

    // With the comparator off, the level is taken as high.
    always_comb begin
        ld_eff = ld_cmp_en ? ld_level : 1'b1;
    end

    always_comb begin
        fall_qual = dld_q && !dld && ld_eff;
    end

    AST_QUAL_NEEDS_LOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall_qual |-> (!dld && $past(dld))); // R2

endmodule

// File: rtl/hold_ref_pick.sv
// Picks the strobe of the selected reference; out-of-range selects give none.
module hold_ref_pick #(
    parameter int NUM_REFS = 3,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_REFS-1:0] ref_edge,
    input  logic [SEL_W-1:0]    ref_sel,
    output logic                ref_strobe
);

    logic [NUM_REFS-1:0] hit;

    for (genvar gi = 0; gi < NUM_REFS; gi++) begin : g_hit
        assign hit[gi] = ref_edge[gi] && (ref_sel == SEL_W'(gi));
    end

    assign ref_strobe = |hit;

endmodule

// File: rtl/hold_relock_timer.sv
// Counts consecutive lock-high cycles while relocking; any low cycle restarts.
module hold_relock_timer #(
    parameter int CLEAN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dld,
    output logic clean_done
);

    localparam int CNT_W = (CLEAN_CYC > 1) ? $clog2(CLEAN_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLEAN_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        clean_done = run && dld && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || !dld || clean_done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R7
    AST_CHATTER_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !dld) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/hold_fsm.sv
// Holdover state machine: state register, next-state logic, registered outputs.
module hold_fsm
    import holdover_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pll_en,
    input  logic fall_qual,
    input  logic ref_strobe,
    input  logic clean_done,
    output logic relock_run,
    output logic cp_hiz,
    output logic bcnt_rst,
    output logic hold_busy
);

    hold_state_t state_q;
    hold_state_t state_d;
    logic        release_ev;

    always_comb begin
        state_d    = state_q;
        release_ev = 1'b0;
        if (!pll_en) begin
            state_d = ST_ARMED;                         // any_to_arm
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (fall_qual) state_d = ST_HOLD;   // arm_to_hold
                end
                ST_HOLD: begin
                    if (ref_strobe) begin
                        state_d    = ST_RELOCK;         // hold_to_relock
                        release_ev = 1'b1;
                    end
                end
                ST_RELOCK: begin
                    if (clean_done) state_d = ST_ARMED; // relock_to_arm
                end
                default: state_d = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_hiz    <= 1'b0;
            bcnt_rst  <= 1'b0;
            hold_busy <= 1'b0;
        end else begin
            cp_hiz    <= (state_d == ST_HOLD);
            bcnt_rst  <= release_ev;
            hold_busy <= (state_d != ST_ARMED);
        end
    end

    assign relock_run = (state_q == ST_RELOCK);

    AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_hiz) |-> $past(fall_qual)); // R2
    AST_RELEASE_WITH_BRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cp_hiz) && $past(pll_en)) |-> bcnt_rst); // R6
    AST_BRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_rst |=> !bcnt_rst); // R6
    AST_DISABLED_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |=> (!cp_hiz && !bcnt_rst)); // R8
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELOCK) |=> (state_q != ST_HOLD)); // R7
    AST_BUSY_WITH_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cp_hiz |-> hold_busy); // R10

endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl #(
    parameter int NUM_REFS  = 3,
    parameter int CLEAN_CYC = 4,
    localparam int SEL_W    = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pll_en,
    input  logic                dld,
    input  logic                ld_level,
    input  logic                ld_cmp_en,
    input  logic [NUM_REFS-1:0] ref_edge,
    input  logic [SEL_W-1:0]    ref_sel,
    output logic                cp_hiz,
    output logic                bcnt_rst,
    output logic                hold_busy
);

    logic fall_qual;
    logic ref_strobe;
    logic relock_run;
    logic clean_done;

    hold_lock_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .dld       (dld),
        .ld_level  (ld_level),
        .ld_cmp_en (ld_cmp_en),
        .fall_qual (fall_qual)
    );

    hold_ref_pick #(
        .NUM_REFS (NUM_REFS),
        .SEL_W    (SEL_W)
    ) u_pick (
        .ref_edge   (ref_edge),
        .ref_sel    (ref_sel),
        .ref_strobe (ref_strobe)
    );

    hold_relock_timer #(
        .CLEAN_CYC (CLEAN_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (relock_run),
        .dld        (dld),
        .clean_done (clean_done)
    );

    hold_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_en     (pll_en),
        .fall_qual  (fall_qual),
        .ref_strobe (ref_strobe),
        .clean_done (clean_done),
        .relock_run (relock_run),
        .cp_hiz     (cp_hiz),
        .bcnt_rst   (bcnt_rst),
        .hold_busy  (hold_busy)
    );

endmodule

// File: tb/sim_pll_holdover_ctrl.sv
`timescale 1ns/1ps
module sim_pll_holdover_ctrl;

    localparam int NREF = 3;

    typedef struct {
        logic  hiz;
        logic  brst;
        logic  busy;
        string req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pll_en = 1'b0;
    logic            dld = 1'b0;
    logic            ld_level = 1'b1;
    logic            ld_cmp_en = 1'b1;
    logic [NREF-1:0] ref_edge = '0;
    logic [1:0]      ref_sel = '0;
    logic            cp_hiz, bcnt_rst, hold_busy;

    int   checks = 0;
    int   fails = 0;
    exp_t sb_q[$];
    bit   done = 1'b0;

    always #5 clk = ~clk;

    pll_holdover_ctrl #(.NUM_REFS(NREF), .CLEAN_CYC(4)) u0 (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .dld(dld),
        .ld_level(ld_level), .ld_cmp_en(ld_cmp_en), .ref_edge(ref_edge),
        .ref_sel(ref_sel), .cp_hiz(cp_hiz), .bcnt_rst(bcnt_rst),
        .hold_busy(hold_busy)
    );

    // Driver: apply one cycle of inputs and queue the outputs expected
    // after the following rising edge.
    task automatic cyc(input logic en, input logic d, input logic ld,
                       input logic cmp, input logic [NREF-1:0] re,
                       input logic [1:0] sel, input logic e_hiz,
                       input logic e_brst, input logic e_busy, input string req);
        exp_t e;
        @(negedge clk);
        pll_en = en; dld = d; ld_level = ld; ld_cmp_en = cmp;
        ref_edge = re; ref_sel = sel;
        e.hiz = e_hiz; e.brst = e_brst; e.busy = e_busy; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (cp_hiz !== e.hiz || bcnt_rst !== e.brst || hold_busy !== e.busy) begin
                    fails++;
                    $display("FAIL %s: hiz/brst/busy actual=%b%b%b expected=%b%b%b",
                             e.req, cp_hiz, bcnt_rst, hold_busy, e.hiz, e.brst, e.busy);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        pll_en = 1'b1; dld = 1'b1;
        @(negedge clk);
        checks++;
        if (cp_hiz !== 1'b0 || bcnt_rst !== 1'b0 || hold_busy !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset outputs actual=%b%b%b expected=000",
                     cp_hiz, bcnt_rst, hold_busy);
        end
        dld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        //   en d  ld cmp ref     sel    hiz brst busy
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R1 no fall after reset");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R1 lock high");
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 1, 0, 1, "R2 entry");
        cyc(1, 0, 1, 1, 3'b010, 2'd0, 1, 0, 1, "R5 unselected strobe");
        cyc(1, 0, 1, 1, 3'b001, 2'd0, 0, 1, 1, "R6 release with brst");
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R6 brst single cycle");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R7 relock count 1");
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R7 chatter no retrigger");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R7 recount 1");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R7 recount 2");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R7 recount 3");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R10 rearmed after clean lock");
        cyc(1, 0, 0, 1, 3'b000, 2'd0, 0, 0, 0, "R3 LD low at fall");
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R3 late LD high ignored");
        cyc(1, 1, 0, 1, 3'b000, 2'd0, 0, 0, 0, "R3 lock again");
        cyc(1, 0, 0, 0, 3'b000, 2'd0, 1, 0, 1, "R4 comparator off entry");
        cyc(1, 0, 0, 0, 3'b111, 2'd3, 1, 0, 1, "R5 out-of-range select");
        cyc(1, 0, 0, 0, 3'b100, 2'd2, 0, 1, 1, "R5 select 2 releases");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R7 count 1");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R7 count 2");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R7 count 3");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R7 clean lock rearms");
        cyc(1, 0, 1, 1, 3'b001, 2'd0, 1, 0, 1, "R9 strobe in entry cycle");
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 1, 0, 1, "R9 still held");
        cyc(1, 0, 1, 1, 3'b001, 2'd0, 0, 1, 1, "R9 later strobe releases");
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 0, 0, 1, "R10 busy in relock");
        cyc(0, 0, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R8 disable leaves relock");
        cyc(0, 1, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R8 disabled lock high");
        cyc(0, 0, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R8 no entry while disabled");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R8 reenable");
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 1, 0, 1, "R2 entry again");
        cyc(0, 0, 1, 1, 3'b001, 2'd0, 0, 0, 0, "R8 disable drops hold no brst");
        cyc(1, 0, 1, 1, 3'b001, 2'd0, 0, 0, 0, "R8 no fall no entry");
        cyc(1, 1, 1, 1, 3'b000, 2'd0, 0, 0, 0, "R2 lock");
        cyc(1, 0, 1, 1, 3'b000, 2'd0, 1, 0, 1, "R2 entry third");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (cp_hiz !== 1'b0 || bcnt_rst !== 1'b0 || hold_busy !== 1'b0) begin
            fails++;
            $display("FAIL R1: mid-run reset actual=%b%b%b expected=000",
                     cp_hiz, bcnt_rst, hold_busy);
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule